// File: doc/BRIEF.md
# Carry-Free Bit Convolution Coefficient Generator

This block takes two vectors of unsigned integers, each element a string of bits, and produces the unresolved coefficient string of their inner product. For each output position `i` it counts how many bit pairs line up at that position: bit `j` of an element of the first vector paired with bit `i-j` of the same element of the second vector, summed over every element. No carries are propagated. Each coefficient is a small multi-level integer that a later stage would weight by `2^i` and add up. That later stage is not part of this block.

A caller places both vectors on the operand inputs and pulses a start strobe. The block captures the operands and then emits one coefficient per clock, lowest position first, with a valid flag. A last flag marks the final coefficient. The stream behaves like the sample sequence a convolver hands to a digitizer.

With a single element, the block reduces to the bit convolution of one scalar product. The coefficient width then shrinks to the count of levels one product can reach.

Top module: `bitconv_coef_gen`

## Requirements
- R1: While reset is held, and after it is released with no start, `coef_valid` and `coef_last` are low and `coef_out` is zero.
- R2: The coefficient at position i equals the number of (element k, bit a, bit b) triples with a+b = i, bit a of element k of `f_vec` set and bit b of element k of `g_vec` set. Element k occupies bits [k*L+L-1 : k*L] of each operand bus, and bit 0 is the least significant.
- R3: One operation emits exactly 2L-1 coefficients, for positions 0 through 2L-2. They appear in ascending order on consecutive cycles, with `coef_valid` high for each.
- R4: If start is sampled high by an idle block at clock edge t, coefficient 0 is presented after edge t+1 and coefficient i after edge t+1+i.
- R5: `coef_last` is high only together with the coefficient of position 2L-2, and only while `coef_valid` is high.
- R6: `coef_valid` is low after the last coefficient until the next accepted start, and `coef_out` reads zero while it is low.
- R7: A start pulse that arrives during an operation is ignored. Operand changes after the accepted start have no effect on the stream being emitted.
- R8: The coefficient width is ceil(log2(N*L+1)) bits. The largest value, N*L, is produced at position L-1 when all operand bits are one, and no coefficient exceeds N*L.
- R9: With N = 1, the block emits the plain bit convolution of one pair of L-bit operands, on ceil(log2(L+1)) output bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when the block is idle |
| f_vec | input | N*L | First operand vector, element k in bits k*L upward |
| g_vec | input | N*L | Second operand vector, same packing |
| coef_out | output | CW | Current coefficient, CW = ceil(log2(N*L+1)) |
| coef_valid | output | 1 | `coef_out` holds a coefficient |
| coef_last | output | 1 | Current coefficient is the one at position 2L-2 |

## Verification
On every cycle, the assertions check the sequencing rules. The position counter stays in range. A start during an operation does not restart the count. A stream opens at position 0 and closes only through a last flag that sits at position 2L-2. No coefficient exceeds N*L. The numeric coefficient values, the latency from start to the first coefficient, and the isolation of a running stream from new operand values can only be shown by the bench scenarios. These scenarios compare each emitted value against a pair-counting model, for several operand patterns and for the single-element configuration.

// File: rtl/bitconv_pkg.sv
package bitconv_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_t;

  // Bits needed to hold every count from 0 to n*l inclusive.
  function automatic int coef_width(input int n, input int l);
    return $clog2(n * l + 1);
  endfunction

  // Bits needed for the position counter over 0 .. 2l-2.
  function automatic int pos_width(input int l);
    return $clog2(2 * l);
  endfunction

endpackage

// File: rtl/bitconv_seq.sv
module bitconv_seq
  import bitconv_pkg::*;
#(
  parameter int LAST = 30,
  parameter int IW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          load,
  output logic          busy,
  output logic          final_step,
  output logic [IW-1:0] idx
);

  seq_state_t state;

  assign busy       = (state == ST_RUN);
  assign load       = start && (state == ST_IDLE);
  assign final_step = busy && (idx == IW'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          idx <= '0;
          if (start) state <= ST_RUN;
        end
        ST_RUN: begin
          if (idx == IW'(LAST)) begin
            state <= ST_IDLE;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: the position counter never leaves 0 .. 2L-2 during a run
  p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx <= IW'(LAST)));

  // R7: a start seen mid-run only lets the count advance by one
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && (idx != IW'(LAST))) |=> (busy && (idx == $past(idx) + 1'b1)));

endmodule

// File: rtl/bitconv_term.sv
module bitconv_term #(
  parameter int L  = 16,
  parameter int IW = 5,
  parameter int LW = 5
) (
  input  logic [L-1:0]  f_bits,
  input  logic [L-1:0]  g_bits,
  input  logic [IW-1:0] idx,
  output logic [LW-1:0] cnt
);

  localparam int XL = 3 * L;
  localparam int XW = $clog2(XL) + 1;

  // Second operand padded by L zeros on each side, so that position
  // idx+L-j addresses g bit idx-j, or a zero when out of range.
  logic [XL-1:0] g_pad;
  logic [L-1:0]  hit;

  assign g_pad = {{L{1'b0}}, g_bits, {L{1'b0}}};

  for (genvar j = 0; j < L; j++) begin : g_tap
    logic [XW-1:0] ofs;
    logic [XL-1:0] shifted;
    assign ofs     = XW'(idx) + XW'(L) - XW'(j);
    assign shifted = g_pad >> ofs;
    assign hit[j]  = f_bits[j] & shifted[0];
  end

  always_comb begin
    cnt = '0;
    for (int j = 0; j < L; j++) begin
      cnt = cnt + LW'(hit[j]);
    end
  end

endmodule

// File: rtl/bitconv_sum.sv
module bitconv_sum #(
  parameter int N  = 32,
  parameter int LW = 5,
  parameter int CW = 10
) (
  input  logic [N-1:0][LW-1:0] parts,
  output logic [CW-1:0]        total
);

  always_comb begin
    total = '0;
    for (int k = 0; k < N; k++) begin
      total = total + CW'(parts[k]);
    end
  end

endmodule

// File: rtl/bitconv_coef_gen.sv
module bitconv_coef_gen
  import bitconv_pkg::*;
#(
  parameter int N = 32,
  parameter int L = 16,
  localparam int CW = coef_width(N, L)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [N*L-1:0] f_vec,
  input  logic [N*L-1:0] g_vec,
  output logic [CW-1:0] coef_out,
  output logic          coef_valid,
  output logic          coef_last
);

  localparam int LAST = 2 * L - 2;
  localparam int IW   = pos_width(L);
  localparam int LW   = $clog2(L + 1);
  localparam int PEAK = N * L;

  logic          load;
  logic          busy;
  logic          final_step;
  logic [IW-1:0] idx;
  logic [IW-1:0] out_idx;

  logic [N*L-1:0]       f_q;
  logic [N*L-1:0]       g_q;
  logic [N-1:0][LW-1:0] part_cnt;
  logic [CW-1:0]        coef_now;

  bitconv_seq #(.LAST(LAST), .IW(IW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .load       (load),
    .busy       (busy),
    .final_step (final_step),
    .idx        (idx)
  );

  // Operands are captured once, so the running stream never sees new input values.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q <= '0;
      g_q <= '0;
    end else if (load) begin
      f_q <= f_vec;
      g_q <= g_vec;
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_elem
    bitconv_term #(.L(L), .IW(IW), .LW(LW)) u_term (
      .f_bits (f_q[k*L +: L]),
      .g_bits (g_q[k*L +: L]),
      .idx    (idx),
      .cnt    (part_cnt[k])
    );
  end

  bitconv_sum #(.N(N), .LW(LW), .CW(CW)) u_sum (
    .parts (part_cnt),
    .total (coef_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_out   <= '0;
      coef_valid <= 1'b0;
      coef_last  <= 1'b0;
      out_idx    <= '0;
    end else begin
      coef_out   <= busy ? coef_now : '0;
      coef_valid <= busy;
      coef_last  <= final_step;
      out_idx    <= idx;
    end
  end

  // R5: the last flag only rides on a valid coefficient
  p_last_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    coef_last |-> coef_valid);

  // R5: the last flag marks position 2L-2
  p_last_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    coef_last |-> (out_idx == IW'(LAST)));

  // R3: every stream opens at position 0
  p_first_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coef_valid) |-> (out_idx == '0));

  // R6: valid only drops right after the last coefficient
  p_valid_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(coef_valid) |-> $past(coef_last));

  // R8: no coefficient exceeds N*L
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    coef_valid |-> (coef_out <= CW'(PEAK)));

endmodule

// File: tb/bitconv_coef_gen_test.sv
module bitconv_coef_gen_test;

  localparam int TN  = 4;
  localparam int TL  = 8;
  localparam int TCW = $clog2(TN * TL + 1);
  localparam int SL  = 8;
  localparam int SCW = $clog2(SL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             start = 1'b0;
  logic [TN*TL-1:0] f_vec = '0;
  logic [TN*TL-1:0] g_vec = '0;
  logic [TCW-1:0]   coef_out;
  logic             coef_valid;
  logic             coef_last;

  logic          s_start = 1'b0;
  logic [SL-1:0] s_f = '0;
  logic [SL-1:0] s_g = '0;
  logic [SCW-1:0] s_coef;
  logic          s_valid;
  logic          s_last;

  bitconv_coef_gen #(.N(TN), .L(TL)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .f_vec(f_vec), .g_vec(g_vec),
    .coef_out(coef_out), .coef_valid(coef_valid), .coef_last(coef_last)
  );

  bitconv_coef_gen #(.N(1), .L(SL)) uut_scalar (
    .clk(clk), .rst_n(rst_n), .start(s_start), .f_vec(s_f), .g_vec(s_g),
    .coef_out(s_coef), .coef_valid(s_valid), .coef_last(s_last)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts aligned bit pairs whose positions add up to pos.
  function automatic int ref_coef(input logic [255:0] fv, input logic [255:0] gv,
                                  input int n, input int l, input int pos);
    int acc = 0;
    for (int k = 0; k < n; k++)
      for (int a = 0; a < l; a++)
        for (int b = 0; b < l; b++)
          if ((a + b == pos) && fv[k*l+a] && gv[k*l+b]) acc++;
    return acc;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(coef_valid == 1'b0, "R1 valid in reset", int'(coef_valid), 0);
    chk(coef_last == 1'b0, "R1 last in reset", int'(coef_last), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(coef_valid == 1'b0, "R1 valid after reset", int'(coef_valid), 0);
    chk(coef_out == '0, "R1 coef after reset", int'(coef_out), 0);
  endtask

  // Runs one full stream; with disturb set, a second start and fresh
  // operand values are applied mid-stream (R7).
  task automatic t_stream(input logic [TN*TL-1:0] fv, input logic [TN*TL-1:0] gv,
                          input bit disturb, input string tag);
    int seen = 0;
    @(negedge clk);
    f_vec = fv;
    g_vec = gv;
    start = 1'b1;
    @(negedge clk);             // edge t has sampled start
    start = 1'b0;
    chk(coef_valid == 1'b0, {"R4 no output yet ", tag}, int'(coef_valid), 0);
    for (int i = 0; i <= 2*TL-2; i++) begin
      @(negedge clk);           // after edge t+1+i
      if (disturb && i == 2) begin
        start = 1'b1;
        f_vec = ~fv;
        g_vec = ~gv ^ 32'h1357_9bdf;
      end else if (disturb && i == 3) begin
        start = 1'b0;
      end
      if (coef_valid) seen++;
      chk(coef_valid == 1'b1, {"R3 valid ", tag}, int'(coef_valid), 1);
      chk(int'(coef_out) == ref_coef(256'(fv), 256'(gv), TN, TL, i),
          {disturb ? "R7 coef " : "R2 coef ", tag}, int'(coef_out),
          ref_coef(256'(fv), 256'(gv), TN, TL, i));
      chk(coef_last == (i == 2*TL-2), {"R5 last ", tag}, int'(coef_last), int'(i == 2*TL-2));
    end
    chk(seen == 2*TL-1, {"R3 count ", tag}, seen, 2*TL-1);
    @(negedge clk);
    chk(coef_valid == 1'b0, {"R6 valid after last ", tag}, int'(coef_valid), 0);
    chk(coef_out == '0, {"R6 coef idle ", tag}, int'(coef_out), 0);
    repeat (3) @(negedge clk);
    chk(coef_valid == 1'b0, {"R6 stays idle ", tag}, int'(coef_valid), 0);
  endtask

  task automatic t_peak();
    int peak = 0;
    int peak_pos = -1;
    @(negedge clk);
    f_vec = '1;
    g_vec = '1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i <= 2*TL-2; i++) begin
      @(negedge clk);
      if (int'(coef_out) > peak) begin
        peak = int'(coef_out);
        peak_pos = i;
      end
    end
    chk(peak == TN * TL, "R8 peak value", peak, TN * TL);
    chk(peak_pos == TL - 1, "R8 peak position", peak_pos, TL - 1);
    chk($bits(coef_out) == TCW, "R8 width", $bits(coef_out), TCW);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_scalar(input logic [SL-1:0] fv, input logic [SL-1:0] gv);
    @(negedge clk);
    s_f = fv;
    s_g = gv;
    s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0;
    for (int i = 0; i <= 2*SL-2; i++) begin
      @(negedge clk);
      chk(s_valid == 1'b1, "R9 scalar valid", int'(s_valid), 1);
      chk(int'(s_coef) == ref_coef(256'(fv), 256'(gv), 1, SL, i), "R9 scalar coef",
          int'(s_coef), ref_coef(256'(fv), 256'(gv), 1, SL, i));
    end
    chk(s_last == 1'b1, "R9 scalar last", int'(s_last), 1);
    @(negedge clk);
    chk(s_valid == 1'b0, "R9 scalar idle", int'(s_valid), 0);
    chk($bits(s_coef) == 4, "R9 scalar width", $bits(s_coef), 4);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    t_reset();
    t_stream(32'h0000_0000, 32'h0000_0000, 1'b0, "zero");
    t_stream(32'h0101_0101, 32'h0101_0101, 1'b0, "unit");
    t_stream(32'hA5C3_7E19, 32'h3CF0_96D2, 1'b0, "mixed");
    t_stream(32'h8000_0001, 32'hFF00_00FF, 1'b0, "edges");
    t_stream(32'h6B2D_F047, 32'hD19E_25A8, 1'b1, "restart");
    t_peak();
    t_scalar(8'hFF, 8'hFF);
    t_scalar(8'hB3, 8'h4D);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule